// File: doc/BRIEF.md
# Buffered Serial Master Transmitter with Chip-Select Word

This block is a clocked serial master that only transmits. Control logic first sets a burst length. It then writes one chip-select word, followed by the data words, which go into a small buffer. When the buffer holds the programmed number of words and transmission is enabled, the block shifts every word out on a serial clock and data line. During the burst it drives active-low chip-select lines from the stored word. After the last word it releases chip-select and pulses a completion interrupt.

Buffer state can be read at all times through three outputs: a full flag, an empty flag and a 4-bit fill pointer. A one-cycle clear command returns the buffer to its starting state. A global operation enable freezes all internal state while it is low. Because the serial clock is derived from the system clock by a programmable divider, one design covers slow and fast peripherals.

Top module: `spi_csbuf_master`

## Requirements
- R1: After reset the outputs are as follows: `sck`=0, `cs_n` all ones, `busy`=0, `empty`=1, `full`=0, `wr_ptr`=0, `overrun`=0 and `done_irq`=0.
- R2: While `op_en`=0, no state changes. Data writes, clears and transmit requests have no effect, and the serial outputs hold their values. A burst that was loaded before `op_en` fell runs once `op_en` returns to 1.
- R3: When `ptr_clr` is high for one cycle while no burst is active, the next cycle shows `full`=0, `empty`=1, `wr_ptr`=0 and `overrun`=0.
- R4: A `cnt_val` of k (1..15) sets a burst of k words, and 0 sets a burst of 16 words. `wr_ptr` reads the number of words stored modulo 16. `full` rises when the stored count reaches the burst length, and `empty` is 0 once any word is stored and not yet sent.
- R5: A data write made while `full`=1 is dropped, so the buffer and `wr_ptr` are unchanged. The write sets `overrun`, which stays at 1 until a clear.
- R6: From the start of a burst until chip-select is released, `cs_n` equals the bitwise inverse of the stored chip-select word, and it stays constant during the burst. At all other times `cs_n` is all ones.
- R7: A burst starts only when `tx_en`=1 and the buffer is full and not yet sent. While `tx_en`=0, `busy` stays 0.
- R8: Every word is sent as 16 bits. It goes MSB first when `lsb_first`=0 and LSB first when `lsb_first`=1, and words are sent in the order they were written.
- R9: `sck` idles low, and each half period lasts `div_sel`+1 clock cycles. `mosi` changes only while `sck` is low, so it is stable at every rising edge of `sck`.
- R10: `busy` is high from the start of the burst until the falling `sck` edge of the last bit. `2*(div_sel+1)` cycles after `busy` falls, `cs_n` returns to all ones and `done_irq` is high for exactly one cycle, with `empty`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Global operation enable; when 0, all state is frozen |
| tx_en | input | 1 | Transmit enable |
| lsb_first | input | 1 | Bit order: 1 sends LSB first |
| div_sel | input | DIV_W | SCK half-period length minus one, in clock cycles |
| ptr_clr | input | 1 | Buffer clear command |
| cnt_we | input | 1 | Write strobe for the burst length |
| cnt_val | input | 4 | Burst length (0 means 16) |
| cs_we | input | 1 | Write strobe for the chip-select word |
| cs_val | input | CS_N | Chip-select word; a 1 bit selects that line |
| dat_we | input | 1 | Write strobe for a data word |
| dat_val | input | 16 | Data word |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | CS_N | Active-low chip-select lines |
| busy | output | 1 | Shifting in progress |
| full | output | 1 | Programmed word count is stored |
| empty | output | 1 | All stored words have been sent |
| wr_ptr | output | 4 | Buffer fill pointer |
| overrun | output | 1 | Sticky flag for a write made while the buffer was full |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
Register writes, clears and dropped writes take effect at the next clock edge. The bench therefore samples on the falling clock edge right after the write cycle. Serial timing is measured against a free-running cycle counter rather than at fixed sample points. The first `sck` rise must come `div_sel`+1 cycles after `busy` rises, and every later `sck` edge must follow the one before by the same interval. The bench measures the gap between `busy` falling and `done_irq` against `2*(div_sel+1)` cycles. It records `cs_n` and `empty` in the same sample as the interrupt and reassembles the words from `mosi` at each rising `sck` edge.

// File: rtl/spi_csbuf_pkg.sv
package spi_csbuf_pkg;
  localparam int WORD_W = 16;
  localparam int CNT_W  = 4;
  localparam int DEPTH  = 1 << CNT_W;
  localparam int BIT_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} eng_state_e;

  // Burst length from the count field: 0 encodes a full buffer.
  function automatic logic [CNT_W:0] burst_len(input logic [CNT_W-1:0] cnt);
    return (cnt == '0) ? (CNT_W+1)'(DEPTH) : {1'b0, cnt};
  endfunction

  // Line bit for position idx of a word under the selected order.
  function automatic logic wire_bit(input logic [WORD_W-1:0] w,
                                    input logic [BIT_W-1:0]  idx,
                                    input logic              lsb_first);
    return lsb_first ? w[idx] : w[BIT_W'(WORD_W-1) - idx];
  endfunction
endpackage

// File: rtl/spi_csbuf_tick.sv
module spi_csbuf_tick #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] hcnt;

  assign tick = ce && run && (hcnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hcnt <= '0;
    else if (ce) begin
      if (!run || tick)      hcnt <= '0;
      else                   hcnt <= hcnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_csbuf_fifo.sv
module spi_csbuf_fifo
  import spi_csbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              clr,
  input  logic              len_we,
  input  logic [CNT_W-1:0]  len_val,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop,
  output logic [WORD_W-1:0] head_word,
  output logic [WORD_W-1:0] next_word,
  output logic              full,
  output logic              empty,
  output logic              last,
  output logic [CNT_W-1:0]  fill_ptr,
  output logic              overrun
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [CNT_W:0]    wcnt, rcnt, len_q;
  logic [CNT_W-1:0]  rd_idx, rd_nxt;
  logic              accept, reject;

  assign full     = (wcnt == len_q);
  assign empty    = (rcnt == wcnt);
  assign last     = ((rcnt + (CNT_W+1)'(1)) == wcnt);
  assign accept   = push && !full;
  assign reject   = push && full;
  assign fill_ptr = wcnt[CNT_W-1:0];
  assign rd_idx   = rcnt[CNT_W-1:0];
  assign rd_nxt   = rd_idx + 1'b1;
  assign head_word = mem[rd_idx];
  assign next_word = mem[rd_nxt];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt    <= '0;
      rcnt    <= '0;
      len_q   <= burst_len('0);
      overrun <= 1'b0;
    end else if (ce) begin
      if (clr) begin
        wcnt    <= '0;
        rcnt    <= '0;
        overrun <= 1'b0;
      end else begin
        if (accept) wcnt    <= wcnt + 1'b1;
        if (reject) overrun <= 1'b1;
        if (pop)    rcnt    <= rcnt + 1'b1;
      end
      if (len_we) len_q <= burst_len(len_val);
    end
  end

  always_ff @(posedge clk) begin
    if (ce && accept && !clr) mem[wcnt[CNT_W-1:0]] <= push_data;
  end
endmodule

// File: rtl/spi_csbuf_shift.sv
module spi_csbuf_shift
  import spi_csbuf_pkg::*;
#(
  parameter int CS_N  = 4,
  parameter int DIV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              start,
  input  logic [CS_N-1:0]   cs_word,
  input  logic              lsb_first,
  input  logic [DIV_W-1:0]  div,
  input  logic [WORD_W-1:0] head_word,
  input  logic [WORD_W-1:0] next_word,
  input  logic              last,
  output logic              sck,
  output logic              mosi,
  output logic [CS_N-1:0]   cs_n,
  output logic              busy,
  output logic              idle,
  output logic              word_done,
  output logic              tail_end
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W-1);

  eng_state_e        state;
  logic [BIT_W-1:0]  bitc;
  logic [WORD_W-1:0] shreg;
  logic              tailc;
  logic              tick;

  spi_csbuf_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .ce(ce), .run(state != ST_IDLE), .div(div), .tick(tick)
  );

  assign idle      = (state == ST_IDLE);
  assign busy      = (state == ST_SHIFT);
  assign word_done = busy && tick && sck && (bitc == LAST_BIT);
  assign tail_end  = (state == ST_TAIL) && tick && tailc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sck   <= 1'b0;
      mosi  <= 1'b0;
      cs_n  <= '1;
      bitc  <= '0;
      shreg <= '0;
      tailc <= 1'b0;
    end else if (ce) begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_SHIFT;
          sck   <= 1'b0;
          shreg <= head_word;
          bitc  <= '0;
          mosi  <= wire_bit(head_word, '0, lsb_first);
          cs_n  <= ~cs_word;
        end
        ST_SHIFT: if (tick) begin
          if (!sck) sck <= 1'b1;
          else begin
            sck <= 1'b0;
            if (bitc == LAST_BIT) begin
              bitc <= '0;
              if (last) begin
                state <= ST_TAIL;
                tailc <= 1'b0;
                mosi  <= 1'b0;
              end else begin
                shreg <= next_word;
                mosi  <= wire_bit(next_word, '0, lsb_first);
              end
            end else begin
              bitc <= bitc + 1'b1;
              mosi <= wire_bit(shreg, bitc + 1'b1, lsb_first);
            end
          end
        end
        ST_TAIL: if (tick) begin
          if (tailc) begin
            state <= ST_IDLE;
            cs_n  <= '1;
          end else tailc <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_csbuf_master.sv
module spi_csbuf_master
  import spi_csbuf_pkg::*;
#(
  parameter int CS_N  = 4,
  parameter int DIV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_en,
  input  logic              tx_en,
  input  logic              lsb_first,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              ptr_clr,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              cs_we,
  input  logic [CS_N-1:0]   cs_val,
  input  logic              dat_we,
  input  logic [WORD_W-1:0] dat_val,
  output logic              sck,
  output logic              mosi,
  output logic [CS_N-1:0]   cs_n,
  output logic              busy,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  wr_ptr,
  output logic              overrun,
  output logic              done_irq
);
  // Named internal events, also observed by the bound checker.
  logic              ce, eng_idle, clr_go, len_go, cs_go, start_go;
  logic              word_done, tail_end, last_word;
  logic [WORD_W-1:0] head_word, next_word;
  logic [CS_N-1:0]   cs_q;

  assign ce       = op_en;
  assign clr_go   = ptr_clr && eng_idle;
  assign len_go   = cnt_we && eng_idle;
  assign cs_go    = cs_we && eng_idle;
  assign start_go = tx_en && full && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= '0;
      done_irq <= 1'b0;
    end else begin
      done_irq <= ce && tail_end;
      if (ce && cs_go) cs_q <= cs_val;
    end
  end

  spi_csbuf_fifo u_fifo (
    .clk(clk), .rst_n(rst_n), .ce(ce), .clr(clr_go),
    .len_we(len_go), .len_val(cnt_val),
    .push(dat_we), .push_data(dat_val), .pop(word_done),
    .head_word(head_word), .next_word(next_word),
    .full(full), .empty(empty), .last(last_word),
    .fill_ptr(wr_ptr), .overrun(overrun)
  );

  spi_csbuf_shift #(.CS_N(CS_N), .DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .ce(ce), .start(start_go),
    .cs_word(cs_q), .lsb_first(lsb_first), .div(div_sel),
    .head_word(head_word), .next_word(next_word), .last(last_word),
    .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy), .idle(eng_idle),
    .word_done(word_done), .tail_end(tail_end)
  );
endmodule

// File: rtl/spi_csbuf_chk.sv
module spi_csbuf_chk
  import spi_csbuf_pkg::*;
#(
  parameter int CS_N = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_en,
  input logic             tx_en,
  input logic             ptr_clr,
  input logic             dat_we,
  input logic             sck,
  input logic             mosi,
  input logic [CS_N-1:0]  cs_n,
  input logic             busy,
  input logic             full,
  input logic             empty,
  input logic [CNT_W-1:0] wr_ptr,
  input logic             overrun,
  input logic             done_irq,
  input logic             eng_idle
);
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> ($stable(sck) && $stable(mosi) && $stable(cs_n) && $stable(wr_ptr) && $stable(overrun)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && ptr_clr && eng_idle) |=> (empty && !full && wr_ptr == '0 && !overrun));

  p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && dat_we && full && !(ptr_clr && eng_idle)) |=> overrun);

  p_cs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cs_n));

  p_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && eng_idle) |=> !busy);

  p_sck_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle |-> !sck);

  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  p_irq_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (empty && cs_n == '1 && !busy));
endmodule

bind spi_csbuf_master spi_csbuf_chk #(.CS_N(CS_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_en(op_en), .tx_en(tx_en), .ptr_clr(ptr_clr),
  .dat_we(dat_we), .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy),
  .full(full), .empty(empty), .wr_ptr(wr_ptr), .overrun(overrun),
  .done_irq(done_irq), .eng_idle(eng_idle)
);

// File: tb/spi_csbuf_master_tb.sv
module spi_csbuf_master_tb;
  localparam int CS_N  = 4;
  localparam int DIV_W = 4;

  // {div[28:25], lsb_first[24], cnt[23:20], cs[19:16], seed[15:0]}
  localparam logic [28:0] VEC [5] = '{
    {4'd0, 1'b0, 4'd1, 4'b1110, 16'hA5C3},
    {4'd1, 1'b1, 4'd3, 4'b0101, 16'h1234},
    {4'd2, 1'b0, 4'd5, 4'b0011, 16'h8001},
    {4'd0, 1'b1, 4'd0, 4'b1000, 16'h7E01},
    {4'd3, 1'b0, 4'd2, 4'b0000, 16'hFFFF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_en = 1'b0, tx_en = 1'b0, lsb_first = 1'b0, ptr_clr = 1'b0;
  logic [DIV_W-1:0] div_sel = '0;
  logic cnt_we = 1'b0, cs_we = 1'b0, dat_we = 1'b0;
  logic [3:0] cnt_val = '0;
  logic [CS_N-1:0] cs_val = '0;
  logic [15:0] dat_val = '0;
  logic sck, mosi, busy, full, empty, overrun, done_irq;
  logic [CS_N-1:0] cs_n;
  logic [3:0] wr_ptr;

  always #4 clk = ~clk;

  spi_csbuf_master #(.CS_N(CS_N), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .tx_en(tx_en), .lsb_first(lsb_first),
    .div_sel(div_sel), .ptr_clr(ptr_clr), .cnt_we(cnt_we), .cnt_val(cnt_val),
    .cs_we(cs_we), .cs_val(cs_val), .dat_we(dat_we), .dat_val(dat_val),
    .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy), .full(full), .empty(empty),
    .wr_ptr(wr_ptr), .overrun(overrun), .done_irq(done_irq)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [15:0] exp_w [16];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: everything sampled on the falling clock edge.
  logic prev_sck = 1'b0, prev_busy = 1'b0, prev_mosi = 1'b0, prev_irq = 1'b0;
  logic rx_bits [512];
  int rx_n = 0, last_edge = 0, half_err = 0, mosi_err = 0, cs_err = 0;
  int fall_cyc = 0, irq_cyc = 0, irq_total = 0, irq_wide = 0, exp_half = 1;
  logic [CS_N-1:0] exp_csn = '1, csn_at_irq = '0;
  logic empty_at_irq = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (busy && !prev_busy) begin
        rx_n = 0; half_err = 0; mosi_err = 0; cs_err = 0; irq_wide = 0; last_edge = cyc;
      end
      if (sck !== prev_sck) begin
        if (cyc - last_edge != exp_half) half_err++;
        last_edge = cyc;
      end
      if (sck && !prev_sck && rx_n < 512) begin rx_bits[rx_n] = mosi; rx_n++; end
      if (mosi !== prev_mosi && sck) mosi_err++;
      if (busy && cs_n !== exp_csn) cs_err++;
      if (!busy && prev_busy) fall_cyc = cyc;
      if (done_irq) begin
        irq_cyc = cyc; irq_total++; csn_at_irq = cs_n; empty_at_irq = empty;
        if (prev_irq) irq_wide++;
      end
    end
    prev_sck = sck; prev_busy = busy; prev_mosi = mosi; prev_irq = done_irq;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic pulse_clr();
    @(negedge clk) ptr_clr = 1'b1;
    @(negedge clk) ptr_clr = 1'b0;
  endtask
  task automatic load_cnt(input logic [3:0] v);
    @(negedge clk) begin cnt_we = 1'b1; cnt_val = v; end
    @(negedge clk) cnt_we = 1'b0;
  endtask
  task automatic load_cs(input logic [CS_N-1:0] v);
    @(negedge clk) begin cs_we = 1'b1; cs_val = v; end
    @(negedge clk) cs_we = 1'b0;
  endtask
  task automatic push(input logic [15:0] d);
    @(negedge clk) begin dat_we = 1'b1; dat_val = d; end
    @(negedge clk) dat_we = 1'b0;
  endtask

  // Clear, program and fill one burst; checks R3 and R4 along the way.
  task automatic load_burst(input logic [3:0] cnt, input logic [CS_N-1:0] cs, input logic [15:0] seed);
    int n;
    n = (cnt == 0) ? 16 : int'(cnt);
    pulse_clr();
    check("R3 flags after clear {full,empty,ovr}", {full, empty, overrun}, 3'b010);
    check("R3 pointer after clear", wr_ptr, 0);
    load_cnt(cnt);
    load_cs(cs);
    exp_csn = ~cs;
    for (int i = 0; i < n; i++) begin
      exp_w[i] = seed ^ (16'(i) * 16'h3B1D);
      push(exp_w[i]);
      if (i == 0) check("R4 empty after first write", empty, 0);
      if (i == n - 2) check("R4 not full one short", full, 0);
    end
    check("R4 full at count", full, 1);
    check("R4 pointer at count", wr_ptr, n % 16);
  endtask

  // Enable, wait for completion, then check serial data and timing.
  task automatic fire_check(input int n);
    int base, wait_n;
    logic [15:0] got;
    base = irq_total;
    exp_half = int'(div_sel) + 1;
    @(negedge clk) begin tx_en = 1'b1; op_en = 1'b1; end
    wait_n = 0;
    while (irq_total == base && wait_n < 20000) begin @(negedge clk); wait_n++; end
    repeat (3) @(negedge clk);
    check("R10 one interrupt per burst", irq_total - base, 1);
    check("R10 interrupt width", irq_wide, 0);
    check("R10 interrupt delay after busy", irq_cyc - fall_cyc, 2 * exp_half);
    check("R10 empty at interrupt", empty_at_irq, 1);
    check("R6 cs released at interrupt", csn_at_irq, {CS_N{1'b1}});
    check("R6 cs during burst", cs_err, 0);
    check("R9 half period", half_err, 0);
    check("R9 mosi stable while sck high", mosi_err, 0);
    check("R9 sck idle low", sck, 0);
    check("R8 bit count", rx_n, n * 16);
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < 16; j++) begin
        if (lsb_first) got[j] = rx_bits[i*16 + j];
        else           got[15 - j] = rx_bits[i*16 + j];
      end
      check("R8 word content", got, exp_w[i]);
    end
  endtask

  initial begin
    op_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sck", sck, 0);
    check("R1 cs_n", cs_n, {CS_N{1'b1}});
    check("R1 {busy,full,empty,ovr,irq}", {busy, full, empty, overrun, done_irq}, 5'b00100);
    check("R1 pointer", wr_ptr, 0);

    for (int v = 0; v < 5; v++) begin
      tx_en = 1'b0;
      div_sel = VEC[v][28:25];
      lsb_first = VEC[v][24];
      load_burst(VEC[v][23:20], VEC[v][19:16], VEC[v][15:0]);
      fire_check((VEC[v][23:20] == 0) ? 16 : int'(VEC[v][23:20]));
    end

    // R7: full buffer, transmit disabled.
    tx_en = 1'b0; div_sel = 4'd1; lsb_first = 1'b0;
    load_burst(4'd2, 4'b1010, 16'h5A5A);
    repeat (40) @(negedge clk);
    check("R7 no burst without tx_en", busy, 0);
    check("R7 cs idle without tx_en", cs_n, {CS_N{1'b1}});

    // R2: operation disabled freezes everything.
    op_en = 1'b0; tx_en = 1'b1;
    repeat (30) @(negedge clk);
    check("R2 no burst while disabled", busy, 0);
    check("R2 sck held", sck, 0);
    pulse_clr();
    check("R2 clear ignored", {full, wr_ptr}, {1'b1, 4'd2});
    push(16'h1111);
    check("R2 write ignored", {overrun, wr_ptr}, {1'b0, 4'd2});
    fire_check(2);

    // R5: write beyond the count.
    tx_en = 1'b0;
    pulse_clr();
    load_cnt(4'd1);
    load_cs(4'b0111);
    exp_csn = ~4'b0111;
    exp_w[0] = 16'hC0DE;
    push(exp_w[0]);
    push(16'hBEEF);
    check("R5 overrun set", overrun, 1);
    check("R5 pointer unchanged", wr_ptr, 1);
    fire_check(1);
    check("R5 overrun sticky", overrun, 1);
    pulse_clr();
    check("R3 clear resets overrun", overrun, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule